// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the configuration word of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 3-bit test select. The word can be set in two ways. A parallel path takes the divide values from pins while an active-low load pin is low. A serial path shifts a 14-bit word in from a slow serial clock and a data pin, and a load strobe moves it into the word. All pins are already synchronous to the system clock `clk`. The serial clock and the strobes are edge-detected on `clk`, and every output is registered, so each takes effect one `clk` cycle after it is sampled.

A small state machine follows the load pins through three named states:

- `ST_PAR`: parallel transparent. It is entered whenever `par_load_n` is low.
- `ST_HOLD`: latched, with serial shifting allowed. It is entered from `ST_PAR` when `par_load_n` rises with `ser_load` low. It is entered from `ST_SPASS` when `ser_load` falls.
- `ST_SPASS`: serial pass-through. It is entered from `ST_HOLD` when `ser_load` rises, which also transfers the shift register into the word. It is entered from `ST_PAR` when `par_load_n` rises with `ser_load` high, and in that case no transfer takes place.

A low `par_load_n` moves the machine from any state to `ST_PAR`. A flag warns when the active feedback value lies below the lockable range.

Top module: `cfg_loader`

## Requirements
- R1: After reset, `m_val` is 250, `n_sel` is 0, `t_sel` is 0 and `m_low` is 0.
- R2: While `par_load_n` is low, `m_val` and `n_sel` follow `m_pins` and `n_pins`, one `clk` cycle after the pins are sampled.
- R3: When `par_load_n` goes high, the last parallel values are kept. Later changes on `m_pins` or `n_pins` have no effect while `par_load_n` stays high.
- R4: While `par_load_n` is low, activity on `ser_clk`, `ser_data` and `ser_load` changes neither the word nor the shift register.
- R5: While `par_load_n` is high, each rising `ser_clk` shifts `ser_data` into bit 0 of the 14-bit shift register, and the older bits move up by one. `shift_out` is bit 13, which is the oldest bit. The serial order is T2, T1, T0, N1, N0, M8 down to M0. With `ser_load` low, shifting leaves the word unchanged.
- R6: A rising `ser_load` while `par_load_n` is high loads the shift register into the word. Bits 8:0 go to M, bits 10:9 go to N and bits 13:11 go to T.
- R7: While `ser_load` stays high, each rising `ser_clk` shifts as in R5 and also loads the shifted contents into the word.
- R8: After `ser_load` falls, the word is held, and further serial shifts leave it unchanged.
- R9: `t_sel` is written only through the serial path. The parallel path never changes it.
- R10: `m_low` is 1 exactly when `m_val` is below 250.
- R11: A serially loaded word stays in place until `par_load_n` goes low. The parallel pins then take over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_load_n | input | 1 | Parallel load enable, active low |
| m_pins | input | 9 | Parallel feedback divide value |
| n_pins | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe |
| m_val | output | 9 | Active feedback divide value |
| n_sel | output | 2 | Active output divide select |
| t_sel | output | 3 | Active test select |
| shift_out | output | 1 | Oldest bit of the shift register |
| m_low | output | 1 | Active feedback value below the lock range |

## Verification
On every cycle the assertions check several rules. The parallel pins must reach the word one cycle after they are sampled, and the test field must stay frozen under parallel load. The word must not move while the machine idles in the latched state with the strobe low. A strobe rise must copy the shift register into M.

Only the bench scenarios can show the rest. These include the serial bit order and the field layout, the pass-through phase while the strobe is high, and the hold after the strobe falls. They also include the override when the parallel pin returns low, and the full sweep of M values against the lock-range flag.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    typedef enum logic [1:0] {
        ST_PAR   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SPASS = 2'd2
    } ld_state_t;

    typedef enum logic [1:0] {
        LD_NONE    = 2'd0,
        LD_PAR     = 2'd1,
        LD_SER_Q   = 2'd2,
        LD_SER_NXT = 2'd3
    } ld_sel_t;
endpackage

// File: rtl/cfg_edge_shift.sv
module cfg_edge_shift #(
    parameter int SR_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_clk,
    input  logic            ser_data,
    input  logic            shift_allow,
    output logic            clk_rise,
    output logic [SR_W-1:0] sr_q,
    output logic [SR_W-1:0] sr_nxt
);
    logic ser_clk_q;

    // Previous sample of the serial clock; follows the pin even in reset.
    always_ff @(posedge clk) begin
        ser_clk_q <= ser_clk;
    end

    assign clk_rise = ser_clk & ~ser_clk_q;
    assign sr_nxt   = {sr_q[SR_W-2:0], ser_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clk_rise && shift_allow) begin
            sr_q <= sr_nxt;
        end
    end
endmodule

// File: rtl/cfg_load_fsm.sv
module cfg_load_fsm
    import cfg_loader_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    par_load_n,
    input  logic    ser_load,
    input  logic    clk_rise,
    output ld_sel_t sel
);
    ld_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (!par_load_n) begin
            state_nxt = ST_PAR;
        end else begin
            unique case (state)
                ST_PAR:   state_nxt = ser_load ? ST_SPASS : ST_HOLD;
                ST_HOLD:  if (ser_load) state_nxt = ST_SPASS;
                ST_SPASS: if (!ser_load) state_nxt = ST_HOLD;
                default:  state_nxt = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        sel = LD_NONE;
        if (!par_load_n) begin
            sel = LD_PAR;
        end else begin
            unique case (state)
                ST_HOLD:  if (ser_load) sel = LD_SER_Q;
                ST_SPASS: if (ser_load && clk_rise) sel = LD_SER_NXT;
                default:  sel = LD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_word_reg.sv
module cfg_word_reg
    import cfg_loader_pkg::*;
#(
    parameter int M_W     = 9,
    parameter int N_W     = 2,
    parameter int T_W     = 3,
    parameter int M_RESET = 250,
    localparam int SR_W   = M_W + N_W + T_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ld_sel_t         sel,
    input  logic [M_W-1:0]  m_pins,
    input  logic [N_W-1:0]  n_pins,
    input  logic [SR_W-1:0] sr_q,
    input  logic [SR_W-1:0] sr_nxt,
    output logic [M_W-1:0]  m_val,
    output logic [N_W-1:0]  n_sel,
    output logic [T_W-1:0]  t_sel
);
    logic [SR_W-1:0] src;

    assign src = (sel == LD_SER_NXT) ? sr_nxt : sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_val <= M_W'(M_RESET);
            n_sel <= '0;
            t_sel <= '0;
        end else begin
            unique case (sel)
                LD_PAR: begin
                    m_val <= m_pins;
                    n_sel <= n_pins;
                end
                LD_SER_Q, LD_SER_NXT: begin
                    m_val <= src[M_W-1:0];
                    n_sel <= src[M_W+N_W-1:M_W];
                    t_sel <= src[SR_W-1:M_W+N_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int M_W     = 9,
    parameter int N_W     = 2,
    parameter int T_W     = 3,
    parameter int M_RESET = 250,
    parameter int M_MIN   = 250
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load_n,
    input  logic [M_W-1:0] m_pins,
    input  logic [N_W-1:0] n_pins,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_sel,
    output logic [T_W-1:0] t_sel,
    output logic           shift_out,
    output logic           m_low
);
    localparam int SR_W = M_W + N_W + T_W;

    logic            clk_rise;
    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] sr_nxt;
    ld_sel_t         sel;

    cfg_edge_shift #(.SR_W(SR_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .shift_allow (par_load_n),
        .clk_rise    (clk_rise),
        .sr_q        (sr_q),
        .sr_nxt      (sr_nxt)
    );

    cfg_load_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_load_n (par_load_n),
        .ser_load   (ser_load),
        .clk_rise   (clk_rise),
        .sel        (sel)
    );

    cfg_word_reg #(
        .M_W     (M_W),
        .N_W     (N_W),
        .T_W     (T_W),
        .M_RESET (M_RESET)
    ) u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .m_pins (m_pins),
        .n_pins (n_pins),
        .sr_q   (sr_q),
        .sr_nxt (sr_nxt),
        .m_val  (m_val),
        .n_sel  (n_sel),
        .t_sel  (t_sel)
    );

    assign shift_out = sr_q[SR_W-1];
    assign m_low     = (m_val < M_W'(M_MIN));
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int M_W  = 9,
    parameter int N_W  = 2,
    parameter int T_W  = 3,
    parameter int SR_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            par_load_n,
    input logic [M_W-1:0]  m_pins,
    input logic [N_W-1:0]  n_pins,
    input logic            ser_load,
    input logic [M_W-1:0]  m_val,
    input logic [N_W-1:0]  n_sel,
    input logic [T_W-1:0]  t_sel,
    input logic [SR_W-1:0] sr_q
);
    // R2
    par_m_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load_n |=> m_val == $past(m_pins));

    // R2
    par_n_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load_n |=> n_sel == $past(n_pins));

    // R9
    t_par_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load_n |=> $stable(t_sel));

    // R3
    hold_m_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_n && $past(par_load_n) && !ser_load && !$past(ser_load))
        |=> $stable(m_val));

    // R6
    strobe_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_n && $past(par_load_n) && ser_load && !$past(ser_load))
        |=> m_val == $past(sr_q[M_W-1:0]));
endmodule

bind cfg_loader cfg_loader_chk #(
    .M_W  (M_W),
    .N_W  (N_W),
    .T_W  (T_W),
    .SR_W (SR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_load_n (par_load_n),
    .m_pins     (m_pins),
    .n_pins     (n_pins),
    .ser_load   (ser_load),
    .m_val      (m_val),
    .n_sel      (n_sel),
    .t_sel      (t_sel),
    .sr_q       (sr_q)
);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load_n = 1'b1;
    logic [8:0] m_pins = '0;
    logic [1:0] n_pins = '0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_sel;
    logic [2:0] t_sel;
    logic       shift_out;
    logic       m_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [13:0] model_sr = '0;

    always #4 clk = ~clk;

    cfg_loader i_cfg_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_load_n (par_load_n),
        .m_pins     (m_pins),
        .n_pins     (n_pins),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_load   (ser_load),
        .m_val      (m_val),
        .n_sel      (n_sel),
        .t_sel      (t_sel),
        .shift_out  (shift_out),
        .m_low      (m_low)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_word(input string req, input int m, input int n, input int t);
        check({req, " m"}, int'(m_val), m);
        check({req, " n"}, int'(n_sel), n);
        check({req, " t"}, int'(t_sel), t);
    endtask

    // One serial bit: the bench mirrors the shift register only when shifting is allowed.
    task automatic ser_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b1;
        settle();
        ser_clk  = 1'b0;
        settle();
        if (par_load_n) model_sr = {model_sr[12:0], b};
    endtask

    // Word layout {T[2:0], N[1:0], M[8:0]}; sent from bit 13 down to bit 0.
    task automatic ser_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic set_strobe(input logic v);
        @(negedge clk);
        ser_load = v;
        settle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [13:0] w;
        int          cur_m;
        int          cur_n;
        int          cur_t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check_word("R1", 250, 0, 0);
        check("R1 m_low", int'(m_low), 0);

        // R2, R10: sweep all M values through the parallel path
        par_load_n = 1'b0;
        for (int m = 0; m < 512; m++) begin
            @(negedge clk);
            m_pins = 9'(m);
            n_pins = 2'(m % 4);
            settle();
            check("R2 m", int'(m_val), m);
            check("R2 n", int'(n_sel), m % 4);
            check("R10 flag", int'(m_low), (m < 250) ? 1 : 0);
            check("R9 t", int'(t_sel), 0);
        end

        // R3: latch on rising par_load_n
        @(negedge clk);
        m_pins = 9'd300;
        n_pins = 2'd2;
        settle();
        par_load_n = 1'b1;
        settle();
        m_pins = 9'd17;
        n_pins = 2'd1;
        settle();
        check_word("R3", 300, 2, 0);

        // R5, R6: several serial words
        for (int k = 0; k < 6; k++) begin
            w = 14'((k * 5231 + 977) % 16384);
            ser_word(w);
            check("R5 hold m", int'(m_val), (k == 0) ? 300 : int'(model_prev_m(k)));
            check("R5 shift_out", int'(shift_out), int'(w[13]));
            set_strobe(1'b1);
            check_word("R6", int'(w[8:0]), int'(w[10:9]), int'(w[13:11]));
            check("R10 serial flag", int'(m_low), (w[8:0] < 250) ? 1 : 0);
            set_strobe(1'b0);
        end

        // R7: pass-through while the strobe is high
        set_strobe(1'b1);
        for (int i = 0; i < 5; i++) begin
            ser_bit(1'(i % 2));
            check_word("R7", int'(model_sr[8:0]), int'(model_sr[10:9]), int'(model_sr[13:11]));
        end

        // R8: falling strobe holds the word
        set_strobe(1'b0);
        cur_m = int'(model_sr[8:0]);
        cur_n = int'(model_sr[10:9]);
        cur_t = int'(model_sr[13:11]);
        ser_word(14'h2AC3);
        check_word("R8", cur_m, cur_n, cur_t);
        check("R5 oldest bit", int'(shift_out), 1);

        // R11: serial word persists against pin changes, then parallel overrides
        @(negedge clk);
        m_pins = 9'd444;
        n_pins = 2'd3;
        settle();
        check_word("R11 persist", cur_m, cur_n, cur_t);
        par_load_n = 1'b0;
        settle();
        check_word("R11 override", 444, 3, cur_t);

        // R4: serial activity while parallel mode is active
        model_sr = model_sr;
        ser_word(14'h1555);
        set_strobe(1'b1);
        ser_bit(1'b1);
        set_strobe(1'b0);
        check_word("R4 word", 444, 3, cur_t);
        check("R4 shift reg", int'(shift_out), int'(model_sr[13]));
        par_load_n = 1'b1;
        settle();
        set_strobe(1'b1);
        check_word("R4 sr intact", int'(model_sr[8:0]), int'(model_sr[10:9]), int'(model_sr[13:11]));
        set_strobe(1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [8:0] model_prev_m(input int k);
        logic [13:0] pw;
        pw = 14'(((k - 1) * 5231 + 977) % 16384);
        return pw[8:0];
    endfunction
endmodule